// File: doc/BRIEF.md
# CAN Transceiver Operating-Mode Controller

This block is the digital core of a fault-tolerant CAN transceiver's mode logic. Two control inputs from the host select one of five operating modes: standby, power-on standby, normal, go-to-sleep and sleep. A mode change is accepted only while the logic supply is above its power-on threshold. Go-to-sleep is a timed transient: the supply-inhibit output stays active for a fixed number of cycles, and the block then falls into sleep and releases it.

While the transceiver is in a low-power mode, two duration filters watch for wake-up. A local wake-up is the wake input moving away from its last accepted level and staying there. A remote wake-up is the bus staying dominant. A qualified wake raises a wake flag, which appears on the receive output and the fault output, and it moves sleep back to standby. In normal mode the receive output carries the bus data and the low-side termination is switched to the logic supply. In every other mode that termination is switched to the battery.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: The control pair {ctl_a_i, ctl_b_i} selects the mode, reported on mode_o, one clock edge after the pair changes: 11 gives normal (2), 01 gives go-to-sleep (3), 00 gives standby (0), 10 gives power-on standby (1). Sleep is reported as 4.
- R2: While vcc_good_i is low, pin changes are not applied. A pair that differs from the last applied pair is applied at the first edge at which vcc_good_i is high.
- R3: Go-to-sleep lasts exactly GTS_CYC cycles with supply_inh_o high. The block then enters sleep, where supply_inh_o is low.
- R4: A pin change during go-to-sleep cancels the timeout and applies the newly decoded mode.
- R5: A local wake is raised at the edge where lwake_i has differed from its accepted level (1 after reset) for WAKE_HOLD+1 consecutive edges. That edge also makes the new level the accepted one. A shorter excursion raises nothing.
- R6: A remote wake is raised once per dominant stretch, at the (DOM_HOLD+1)-th consecutive edge with bus_dominant_i high.
- R7: Outside normal mode, rx_out_o is 1 while no wake has been recorded and 0 after a wake.
- R8: A wake in sleep returns the block to standby, with supply_inh_o high again.
- R9: In normal mode rx_out_o equals the inverse of bus_dominant_i and lterm_vcc_o is 1. In all other modes lterm_vcc_o is 0, and wakes arriving in normal mode are not recorded.
- R10: Entering normal mode clears the wake flag.
- R11: After reset the block is in standby with rx_out_o=1, fault_n_o=1 and lterm_vcc_o=0.
- R12: In power-on standby, fault_n_o is 0 until normal mode has been entered once after reset. In normal mode it is 1. In the other modes it follows rx_out_o.
- R13: supply_inh_o is low whenever vbat_good_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, held while the supply is below threshold |
| vcc_good_i | input | 1 | Logic supply above power-on threshold |
| vbat_good_i | input | 1 | Battery present |
| ctl_a_i | input | 1 | Mode control pin A (stay-awake role) |
| ctl_b_i | input | 1 | Mode control pin B (enable role) |
| lwake_i | input | 1 | Local wake pin, synchronous to clk |
| bus_dominant_i | input | 1 | Sampled bus-dominant indication |
| rx_out_o | output | 1 | Received data in normal mode, inverted wake flag otherwise |
| fault_n_o | output | 1 | Active-low fault / flag output |
| supply_inh_o | output | 1 | Supply inhibit output (1 = regulator enabled) |
| lterm_vcc_o | output | 1 | 1 = low-side termination to Vcc, 0 = to Vbat |
| mode_o | output | 3 | Current mode code |

## Verification
Mode changes from the pins show on mode_o one edge after the pins are driven. Go-to-sleep falls into sleep GTS_CYC edges after it is entered. A wake shows on rx_out_o after WAKE_HOLD+1 or DOM_HOLD+1 edges of a held input. In normal mode, rx_out_o and the two supply-dependent outputs respond combinationally, with no edge. The bench drives inputs 5 ns after a rising edge and compares every output against a cycle model at each falling edge. Directed checks count edges from the drive point, so each sample lands after the edge that is due to change the output.

// File: rtl/can_xcvr_mode_pkg.sv
// Package: mode codes and pin decoding shared by the mode controller.
// Assumes the control pair is presented as {pin A, pin B}.
package can_xcvr_mode_pkg;

    typedef enum logic [2:0] {
        MODE_STBY    = 3'd0,
        MODE_PWRON   = 3'd1,
        MODE_NORMAL  = 3'd2,
        MODE_GOSLEEP = 3'd3,
        MODE_SLEEP   = 3'd4
    } xcvr_mode_e;

    // Map the two control pins onto the requested mode.
    function automatic xcvr_mode_e decode_pins(input logic [1:0] pins);
        unique case (pins)
            2'b11:   return MODE_NORMAL;
            2'b01:   return MODE_GOSLEEP;
            2'b10:   return MODE_PWRON;
            default: return MODE_STBY;
        endcase
    endfunction

endpackage

// File: rtl/can_wake_filter.sv
// Duration filter for wake sources. With TRACK_LEVEL=1 it qualifies a move
// of the input away from its accepted level and then adopts the new level.
// With TRACK_LEVEL=0 it qualifies a stretch of high input, once per stretch.
// Assumes sig_i is already synchronous to clk and HOLD_CYC >= 1.
module can_wake_filter #(
    parameter int unsigned HOLD_CYC    = 1000,
    parameter bit          TRACK_LEVEL = 1'b1,
    parameter bit          REF_INIT    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic evt_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);
    localparam logic [CW-1:0] SAT = CW'(HOLD_CYC + 1);

    logic          active;
    logic [CW-1:0] cnt_q;

    generate
        if (TRACK_LEVEL) begin : g_level
            logic ref_q;
            // Accepted level: takes the new level when a change qualifies.
            always_ff @(posedge clk) begin
                if (!rst_n)     ref_q <= REF_INIT;
                else if (evt_o) ref_q <= sig_i;
            end
            assign active = sig_i != ref_q;
        end else begin : g_high
            assign active = sig_i;
        end
    endgenerate

    assign evt_o = active && (cnt_q == LIM);

    // Count consecutive active cycles, saturating beyond the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt_q <= '0;
        else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end

    // R5/R6: a qualified wake is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
    // R6: a wake is only raised after the source was already active
    a_r6_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(active));

endmodule

// File: rtl/can_xcvr_mode_fsm.sv
// Mode state machine: applies pin changes while the supply is good, times
// go-to-sleep into sleep, returns sleep to standby on wake, and keeps the
// wake flag and the power-on flag. Assumes wake_evt_i is a one-cycle pulse.
module can_xcvr_mode_fsm
    import can_xcvr_mode_pkg::*;
#(
    parameter int unsigned GTS_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_good_i,
    input  logic [1:0] pins_i,
    input  logic       wake_evt_i,
    output xcvr_mode_e mode_o,
    output logic       wake_flag_o,
    output logic       por_flag_o
);
    localparam int unsigned GW = $clog2(GTS_CYC + 1);
    localparam logic [GW-1:0] GTS_LAST = GW'(GTS_CYC - 1);

    xcvr_mode_e    mode_q, mode_n;
    logic [1:0]    last_q;
    logic [GW-1:0] gts_cnt_q;
    logic          flag_q, por_q;
    logic          pin_chg, gts_done;

    assign pin_chg  = vcc_good_i && (pins_i != last_q);
    assign gts_done = (mode_q == MODE_GOSLEEP) && (gts_cnt_q == GTS_LAST);

    // Next mode: pin change first, then timeout, then wake from sleep.
    always_comb begin
        mode_n = mode_q;
        if (pin_chg)                                mode_n = decode_pins(pins_i);
        else if (gts_done)                          mode_n = MODE_SLEEP;
        else if (mode_q == MODE_SLEEP && wake_evt_i) mode_n = MODE_STBY;
    end

    // Mode register and last applied pin pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STBY;
            last_q <= 2'b00;
        end else begin
            mode_q <= mode_n;
            if (pin_chg) last_q <= pins_i;
        end
    end

    // Go-to-sleep timer, restarted whenever the mode is not go-to-sleep.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_q != MODE_GOSLEEP) gts_cnt_q <= '0;
        else                                  gts_cnt_q <= gts_cnt_q + 1'b1;
    end

    // Wake flag and power-on flag, both cleared on entry to normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            por_q  <= 1'b1;
        end else if (mode_n == MODE_NORMAL) begin
            flag_q <= 1'b0;
            por_q  <= 1'b0;
        end else if (wake_evt_i && mode_q != MODE_NORMAL) begin
            flag_q <= 1'b1;
        end
    end

    assign mode_o      = mode_q;
    assign wake_flag_o = flag_q;
    assign por_flag_o  = por_q;

    // R2: with the supply low, pin-selected modes do not move
    a_r2_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_good_i && mode_q != MODE_GOSLEEP && mode_q != MODE_SLEEP)
        |=> (mode_q == $past(mode_q)));
    // R3: sleep is entered only out of go-to-sleep
    a_r3_sleep_from_gts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP && $past(mode_q) != MODE_SLEEP)
        |-> ($past(mode_q) == MODE_GOSLEEP));
    // R10: no wake flag is ever held in normal mode
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL) |-> !flag_q);
    // R4: a pin change out of go-to-sleep never lands in sleep
    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_GOSLEEP && pin_chg) |=> (mode_q != MODE_SLEEP));

endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
// Top of the transceiver mode controller: two wake filters, the mode
// state machine and the output multiplexing for receive data, fault flag,
// supply inhibit and termination select. Assumes all inputs are synchronous
// to clk and that rst_n is held low while the logic supply is below threshold.
module can_xcvr_mode_ctrl
    import can_xcvr_mode_pkg::*;
#(
    parameter int unsigned GTS_CYC   = 250000,
    parameter int unsigned WAKE_HOLD = 2000,
    parameter int unsigned DOM_HOLD  = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_good_i,
    input  logic       vbat_good_i,
    input  logic       ctl_a_i,
    input  logic       ctl_b_i,
    input  logic       lwake_i,
    input  logic       bus_dominant_i,
    output logic       rx_out_o,
    output logic       fault_n_o,
    output logic       supply_inh_o,
    output logic       lterm_vcc_o,
    output logic [2:0] mode_o
);
    logic       loc_evt, rem_evt, wake_evt;
    logic       wake_flag, por_flag;
    xcvr_mode_e mode;

    // Local wake: qualifies a held change of the wake pin level.
    can_wake_filter #(.HOLD_CYC(WAKE_HOLD), .TRACK_LEVEL(1'b1), .REF_INIT(1'b1)) u_loc_wake (
        .clk(clk), .rst_n(rst_n), .sig_i(lwake_i), .evt_o(loc_evt)
    );

    // Remote wake: qualifies a held dominant bus.
    can_wake_filter #(.HOLD_CYC(DOM_HOLD), .TRACK_LEVEL(1'b0), .REF_INIT(1'b0)) u_rem_wake (
        .clk(clk), .rst_n(rst_n), .sig_i(bus_dominant_i), .evt_o(rem_evt)
    );

    assign wake_evt = loc_evt | rem_evt;

    can_xcvr_mode_fsm #(.GTS_CYC(GTS_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vcc_good_i(vcc_good_i),
        .pins_i({ctl_a_i, ctl_b_i}), .wake_evt_i(wake_evt),
        .mode_o(mode), .wake_flag_o(wake_flag), .por_flag_o(por_flag)
    );

    // Output selection by mode.
    always_comb begin
        lterm_vcc_o  = (mode == MODE_NORMAL);
        supply_inh_o = vbat_good_i && (mode != MODE_SLEEP);
        if (mode == MODE_NORMAL) begin
            rx_out_o  = !bus_dominant_i;
            fault_n_o = 1'b1;
        end else begin
            rx_out_o  = !wake_flag;
            fault_n_o = (mode == MODE_PWRON) ? !por_flag : !wake_flag;
        end
    end

    assign mode_o = mode;

    // R9: termination on Vcc implies the fault output is idle
    a_r9_normal_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        lterm_vcc_o |-> fault_n_o);
    // R13: no supply enable without battery
    a_r13_inh_battery: assert property (@(posedge clk) disable iff (!rst_n)
        supply_inh_o |-> vbat_good_i);

endmodule

// File: tb/can_xcvr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_xcvr_mode_ctrl_bench;
    localparam int GTS  = 20;
    localparam int WH   = 4;
    localparam int DH   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_good = 1'b1, vbat_good = 1'b1, ca = 1'b0, cb = 1'b0;
    logic lwake = 1'b1, dom = 1'b0;
    logic rx, fault_n, inh, lterm;
    logic [2:0] mode;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_xcvr_mode_ctrl #(.GTS_CYC(GTS), .WAKE_HOLD(WH), .DOM_HOLD(DH)) u_can_xcvr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .vcc_good_i(vcc_good), .vbat_good_i(vbat_good),
        .ctl_a_i(ca), .ctl_b_i(cb), .lwake_i(lwake), .bus_dominant_i(dom),
        .rx_out_o(rx), .fault_n_o(fault_n), .supply_inh_o(inh),
        .lterm_vcc_o(lterm), .mode_o(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, written from the requirements
    logic [2:0] m_mode;
    logic [1:0] m_last;
    int m_gts, m_lcnt, m_rcnt;
    logic m_lref, m_flag, m_por;
    logic chg, la, le, re, ev;
    logic [2:0] nm;

    function automatic logic [2:0] dec(input logic a, input logic b);
        case ({a, b})
            2'b11: return 3'd2;
            2'b01: return 3'd3;
            2'b10: return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic exp_rx(input logic [2:0] md, input logic d, input logic f);
        return (md == 3'd2) ? !d : !f;
    endfunction

    function automatic logic exp_fault(input logic [2:0] md, input logic f, input logic p);
        if (md == 3'd2) return 1'b1;
        if (md == 3'd1) return !p;
        return !f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 3'd0; m_last = 2'b00; m_gts = 0; m_lcnt = 0; m_rcnt = 0;
            m_lref = 1'b1; m_flag = 1'b0; m_por = 1'b1;
        end else begin
            chg = vcc_good && ({ca, cb} != m_last);
            la  = (lwake != m_lref);
            le  = la && (m_lcnt == WH);
            re  = dom && (m_rcnt == DH);
            ev  = le | re;
            if (chg) nm = dec(ca, cb);
            else if (m_mode == 3'd3 && m_gts == GTS - 1) nm = 3'd4;
            else if (m_mode == 3'd4 && ev) nm = 3'd0;
            else nm = m_mode;
            if (nm == 3'd2) begin m_flag = 1'b0; m_por = 1'b0; end
            else if (ev && m_mode != 3'd2) m_flag = 1'b1;
            m_gts  = (m_mode == 3'd3) ? m_gts + 1 : 0;
            m_lcnt = !la ? 0 : (m_lcnt != WH + 1 ? m_lcnt + 1 : m_lcnt);
            m_rcnt = !dom ? 0 : (m_rcnt != DH + 1 ? m_rcnt + 1 : m_rcnt);
            if (le) m_lref = lwake;
            if (chg) m_last = {ca, cb};
            m_mode = nm;
        end
    end

    // Cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 mode", mode, m_mode);
            chk("R7 rx_out", rx, exp_rx(m_mode, dom, m_flag));
            chk("R3 supply_inh", inh, vbat_good && (m_mode != 3'd4));
            chk("R9 lterm", lterm, m_mode == 3'd2);
            chk("R12 fault_n", fault_n, exp_fault(m_mode, m_flag, m_por));
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic pins(input logic a, input logic b);
        ca = a; cb = b;
    endtask

    initial begin
        int seed;
        int r;
        seed = 2024;
        r = $urandom(seed);
        edges(3);
        // R11: reset state
        chk("R11 mode", mode, 0); chk("R11 rx_out", rx, 1);
        chk("R11 fault_n", fault_n, 1); chk("R11 lterm", lterm, 0);
        rst_n = 1'b1;
        edges(1);
        // R12: power-on standby shows power-on flag
        pins(1, 0); edges(1);
        chk("R1 pwron", mode, 1); chk("R12 fault_n pwron", fault_n, 0);
        // R1 / R9: normal mode
        pins(1, 1); edges(1);
        chk("R1 normal", mode, 2); chk("R9 lterm", lterm, 1); chk("R12 fault_n normal", fault_n, 1);
        dom = 1'b1; #1; chk("R9 rx dominant", rx, 0);
        dom = 1'b0; #1; chk("R9 rx recessive", rx, 1);
        // R5: short and long local wake in standby
        pins(0, 0); edges(1); chk("R1 standby", mode, 0);
        lwake = 1'b0; edges(WH); chk("R5 short hold", rx, 1);
        lwake = 1'b1; edges(2); chk("R5 no wake", rx, 1);
        lwake = 1'b0; edges(WH + 1); chk("R5 wake", rx, 0); chk("R7 fault", fault_n, 0);
        // R10: normal clears flag
        pins(1, 1); edges(1); pins(0, 0); edges(1); chk("R10 cleared", rx, 1);
        // R6: remote wake
        dom = 1'b1; edges(DH); chk("R6 short dom", rx, 1);
        edges(1); chk("R6 wake", rx, 0);
        dom = 1'b0; edges(1);
        // R2: pins ignored while supply low
        vcc_good = 1'b0; pins(1, 1); edges(3); chk("R2 ignored", mode, 0);
        vcc_good = 1'b1; edges(1); chk("R2 applied", mode, 2);
        // R3: go-to-sleep timing
        pins(0, 1); edges(1); chk("R3 gts", mode, 3); chk("R3 inh gts", inh, 1);
        edges(GTS - 1); chk("R3 still gts", mode, 3); chk("R3 inh held", inh, 1);
        edges(1); chk("R3 sleep", mode, 4); chk("R3 inh off", inh, 0);
        // R8: local wake in sleep (accepted level is 0 now)
        lwake = 1'b1; edges(WH + 1);
        chk("R8 standby", mode, 0); chk("R8 inh", inh, 1); chk("R8 flag", rx, 0);
        // R4: cancel go-to-sleep
        pins(1, 1); edges(1); pins(0, 1); edges(6);
        pins(0, 0); edges(1); chk("R4 cancel", mode, 0);
        edges(GTS); chk("R4 no sleep", mode, 0);
        // R13: no battery, no supply enable
        vbat_good = 1'b0; #1; chk("R13 inh", inh, 0);
        vbat_good = 1'b1; edges(1);
        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 40 == 0) pins($urandom % 2, $urandom % 2);
            vcc_good  = ($urandom % 30 != 0);
            vbat_good = ($urandom % 80 != 0);
            if ($urandom % 9 == 0) lwake = ~lwake;
            if ($urandom % 7 == 0) dom = ~dom;
            edges(1);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule